// File: doc/BRIEF.md
# Delay-Aligned Signal Pair Equivalence Tracker

This block watches a fixed list of source/sink signal pairs while some other design runs its verification tests. Each pair has its own latency in clock samples. On every accepted sample it compares the sink with the source as that source was the given number of samples earlier. Every pair begins a run marked as equivalent. A pair loses that mark on its first disagreement and never gets it back during the run.

When the run ends, the pairs still marked show where the logic between source and sink never changed the value that reached the sink. Such logic could be replaced by a wire plus a delay line without any test noticing. The block takes packed source and sink buses, one lane per pair. A start pulse opens a run and a done pulse closes it. The surviving set comes out as a bit vector together with its population count. Building the list of pairs and their latencies is left to whatever instantiates the block.

Top module: `pair_equiv_tracker`

## Requirements
- R1: A `start` pulse marks every pair as equivalent (all `survivors` bits 1 on the following cycle), sets the run active and restarts the sample count of the run.
- R2: Pair i occupies bits [i*DATA_W +: DATA_W] of `src_bus` and `snk_bus`. Its latency d is field [i*8 +: 8] of `PAIR_DELAYS`. On an accepted sample the sink is compared with the source value of the accepted sample d samples earlier, and with the same sample when d is 0.
- R3: When an accepted sample finds a pair's values unequal, that pair's `survivors` bit (bit i) reads 0 from the clock edge that takes the sample.
- R4: A cleared pair stays cleared until the next `start`, even when its values agree again.
- R5: A pair with latency d is not compared during the first d accepted samples after `start`, so values from before the run cannot clear it.
- R6: A cycle with `sample_en` low neither compares nor advances any pair's source history.
- R7: `done` ends the run. From then on `survivors` holds still and samples are ignored until the next `start`.
- R8: In the same cycle, `start` takes precedence over `done` and `sample_en`, and `done` takes precedence over `sample_en`. A sample that arrives with either of them is discarded.
- R9: `survivor_cnt` always equals the number of 1 bits in `survivors`.
- R10: After reset, `survivors` is all ones, `survivor_cnt` equals NUM_PAIRS and the block is idle, so samples are ignored until `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a run and re-marks all pairs as equivalent |
| sample_en | input | 1 | The current bus values form one sample |
| done | input | 1 | Closes the run and freezes the result |
| src_bus | input | NUM_PAIRS*DATA_W | Packed source values, one lane per pair |
| snk_bus | input | NUM_PAIRS*DATA_W | Packed sink values, one lane per pair |
| survivors | output | NUM_PAIRS | Bit i is 1 while pair i has never mismatched in this run |
| survivor_cnt | output | $clog2(NUM_PAIRS+1) | Number of surviving pairs |

## Verification
A fault in a pair's history line shows up as an aligned comparison against the wrong older value. The bench therefore feeds sinks that match only the correctly delayed source. A one-slot misalignment then clears a `survivors` bit on the very next edge. A fill counter that is too short, or one that is not restarted, drops a pair during its warm-up samples, which the bench fills with garbage sink values. A sticky bit that can be set again, or a run flag that stays open after `done`, shows up as a bit that returns to 1, or as a cleared bit after a mismatching sample that should have been ignored. In each case the fault appears on the cycle after the offending sample. A two-level multiplexer driven through three control steps must leave only the direct good-to-output path in the set.

// File: rtl/eqv_pkg.sv
package eqv_pkg;
   localparam int DLY_FIELD_W = 8;
   typedef enum logic {
      TRK_IDLE = 1'b0,
      TRK_RUN  = 1'b1
   } trk_state_e;
endpackage

// File: rtl/eqv_delay_line.sv
module eqv_delay_line #(
   parameter int DATA_W = 8,
   parameter int TAP    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   generate
      if (TAP == 0) begin : g_wire
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, shift};
         assign dout = din;
      end else begin : g_line
         logic [DATA_W-1:0] stage [TAP];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < TAP; k++) stage[k] <= '0;
            end else if (shift) begin
               stage[0] <= din;
               for (int k = 1; k < TAP; k++) stage[k] <= stage[k-1];
            end
         end
         assign dout = stage[TAP-1];
      end
   endgenerate
endmodule

// File: rtl/eqv_pair_lane.sv
module eqv_pair_lane #(
   parameter int DATA_W = 8,
   parameter int TAP    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              samp,
   input  logic              ready,
   input  logic [DATA_W-1:0] src,
   input  logic [DATA_W-1:0] snk,
   output logic              alive
);
   logic [DATA_W-1:0] src_aligned;
   logic              miss;

   eqv_delay_line #(.DATA_W(DATA_W), .TAP(TAP)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (samp),
      .din   (src),
      .dout  (src_aligned)
   );

   assign miss = samp && ready && (snk != src_aligned);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    alive <= 1'b1;
      else if (clr)  alive <= 1'b1;
      else if (miss) alive <= 1'b0;
   end

   AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!alive && !clr) |=> !alive); // R4
   AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (samp && !ready && !clr) |=> (alive == $past(alive))); // R5
endmodule

// File: rtl/eqv_popcount.sv
module eqv_popcount #(
   parameter int N = 4,
   localparam int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
   end
endmodule

// File: rtl/pair_equiv_tracker.sv
module pair_equiv_tracker
   import eqv_pkg::*;
#(
   parameter int NUM_PAIRS = 4,
   parameter int DATA_W    = 8,
   parameter int MAX_DELAY = 3,
   parameter logic [NUM_PAIRS*DLY_FIELD_W-1:0] PAIR_DELAYS = {8'd3, 8'd2, 8'd1, 8'd0},
   localparam int BUS_W  = NUM_PAIRS * DATA_W,
   localparam int CNT_W  = $clog2(NUM_PAIRS + 1),
   localparam int FILL_W = $clog2(MAX_DELAY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             sample_en,
   input  logic             done,
   input  logic [BUS_W-1:0] src_bus,
   input  logic [BUS_W-1:0] snk_bus,
   output logic [NUM_PAIRS-1:0] survivors,
   output logic [CNT_W-1:0]     survivor_cnt
);
   trk_state_e        state;
   logic [FILL_W-1:0] fill;
   logic              samp_go;

   generate
      if (MAX_DELAY < 1) begin : g_bad_depth
         $error("MAX_DELAY must be at least 1");
      end
      if (NUM_PAIRS < 1) begin : g_bad_pairs
         $error("NUM_PAIRS must be at least 1");
      end
   endgenerate

   assign samp_go = (state == TRK_RUN) && sample_en && !start && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TRK_IDLE;
         fill  <= '0;
      end else if (start) begin
         state <= TRK_RUN;
         fill  <= '0;
      end else if (done) begin
         state <= TRK_IDLE;
      end else if (samp_go && (int'(fill) < MAX_DELAY)) begin
         fill <= fill + 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_lane
         localparam int TAP = int'(PAIR_DELAYS[g*DLY_FIELD_W +: DLY_FIELD_W]);
         if (TAP > MAX_DELAY) begin : g_bad_tap
            $error("pair latency exceeds MAX_DELAY");
         end
         logic ready;
         assign ready = (int'(fill) >= TAP);
         eqv_pair_lane #(.DATA_W(DATA_W), .TAP(TAP)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .samp  (samp_go),
            .ready (ready),
            .src   (src_bus[g*DATA_W +: DATA_W]),
            .snk   (snk_bus[g*DATA_W +: DATA_W]),
            .alive (survivors[g])
         );
      end
   endgenerate

   eqv_popcount #(.N(NUM_PAIRS)) u_count (
      .vec (survivors),
      .cnt (survivor_cnt)
   );

   AST_START_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (&survivors)); // R1
   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TRK_IDLE && !start) |=> $stable(survivors)); // R7
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (state == TRK_IDLE)); // R8
   AST_COUNT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      survivor_cnt == CNT_W'($countones(survivors))); // R9
endmodule

// File: tb/sim_pair_equiv_tracker.sv
module sim_pair_equiv_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic        start, sample_en, done;
   logic [31:0] src_bus, snk_bus;
   logic [3:0]  survivors;
   logic [2:0]  survivor_cnt;

   pair_equiv_tracker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample_en), .done(done),
      .src_bus(src_bus), .snk_bus(snk_bus),
      .survivors(survivors), .survivor_cnt(survivor_cnt)
   );

   logic        m_start, m_samp, m_done;
   logic [63:0] m_src, m_snk;
   logic [7:0]  m_surv;
   logic [3:0]  m_cnt;

   pair_equiv_tracker #(.NUM_PAIRS(8), .DATA_W(8), .MAX_DELAY(1), .PAIR_DELAYS(64'd0)) u1 (
      .clk(clk), .rst_n(rst_n), .start(m_start), .sample_en(m_samp), .done(m_done),
      .src_bus(m_src), .snk_bus(m_snk),
      .survivors(m_surv), .survivor_cnt(m_cnt)
   );

   // row: start, sample, done, shared source byte, sinks {p3,p2,p1,p0}, expected survivors
   typedef struct packed {
      logic        st;
      logic        sm;
      logic        dn;
      logic [7:0]  s;
      logic [31:0] k;
      logic [3:0]  e;
   } row_t;

   localparam row_t TBL [NROWS] = '{
      {1'b1, 1'b0, 1'b0, 8'h00, 32'h00000000, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h0A, 32'h6363630A, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h14, 32'h37370A14, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h1E, 32'h4D0A141E, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h28, 32'h0A141E28, 4'b1111},
      {1'b0, 1'b0, 1'b0, 8'h00, 32'h04030201, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h32, 32'h151E2832, 4'b0111},
      {1'b0, 1'b1, 1'b0, 8'h3C, 32'h1E28323D, 4'b0110},
      {1'b0, 1'b1, 1'b0, 8'h46, 32'h28323C46, 4'b0110},
      {1'b0, 1'b1, 1'b1, 8'h50, 32'h00000000, 4'b0110},
      {1'b0, 1'b1, 1'b0, 8'h5A, 32'h00000000, 4'b0110},
      {1'b1, 1'b0, 1'b0, 8'h00, 32'h00000000, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h05, 32'h00000005, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h06, 32'h09090506, 4'b1111},
      {1'b1, 1'b1, 1'b0, 8'h01, 32'h02020202, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h07, 32'h08080807, 4'b1111},
      {1'b0, 1'b1, 1'b0, 8'h08, 32'h09090708, 4'b1111}
   };

   function automatic string tag_of(input int r);
      case (r)
         0, 11:        return "R1";
         1, 2, 3:      return "R5";
         4, 8:         return "R2";
         5:            return "R6";
         6:            return "R3";
         7:            return "R4";
         9, 14:        return "R8";
         10:           return "R7";
         default:      return "R5";
      endcase
   endfunction

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ones(input logic [7:0] v);
      int c = 0;
      for (int i = 0; i < 8; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic mux_step(input logic [1:0] ctl);
      logic [7:0] good, atk, x, y, o;
      good = 8'h11; atk = 8'hAA;
      x = ctl[0] ? atk : good;
      y = ctl[1] ? atk : good;
      o = ctl[0] ? y : x;
      // pairs 0..7: (G,X) (A,X) (G,Y) (A,Y) (G,O) (A,O) (X,O) (Y,O)
      m_src = {y, x, atk, good, atk, good, atk, good};
      m_snk = {o, o, o, o, y, y, x, x};
      m_samp = 1'b1;
      @(negedge clk);
      m_samp = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run did not complete");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      start = 0; sample_en = 0; done = 0; src_bus = '0; snk_bus = '0;
      m_start = 0; m_samp = 0; m_done = 0; m_src = '0; m_snk = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk("R10 survivors after reset", 32'(survivors), 32'hF);
      chk("R10 count after reset", 32'(survivor_cnt), 32'd4);
      // R10: idle after reset, mismatching sample ignored
      sample_en = 1'b1; src_bus = 32'h01010101; snk_bus = 32'h02020202;
      @(negedge clk);
      sample_en = 1'b0;
      chk("R10 idle sample ignored", 32'(survivors), 32'hF);

      for (int r = 0; r < NROWS; r++) begin
         start = TBL[r].st; sample_en = TBL[r].sm; done = TBL[r].dn;
         src_bus = {4{TBL[r].s}}; snk_bus = TBL[r].k;
         @(negedge clk);
         chk(tag_of(r), 32'(survivors), 32'(TBL[r].e));
         chk("R9 count", 32'(survivor_cnt), 32'(ones({4'b0, TBL[r].e})));
      end
      start = 0; sample_en = 0; done = 0;

      // R2 / R4: two-level multiplexer, zero-latency pairs
      m_start = 1'b1;
      @(negedge clk);
      m_start = 1'b0;
      chk("R1 mux start", 32'(m_surv), 32'hFF);
      mux_step(2'b00);
      chk("R2 mux step 00", 32'(m_surv), 32'hDF & 32'hF5 | 32'h00);
      mux_step(2'b01);
      mux_step(2'b10);
      chk("R2 mux survivor set", 32'(m_surv), 32'h10);
      mux_step(2'b00);
      chk("R4 mux sticky after agreement", 32'(m_surv), 32'h10);
      chk("R9 mux count", 32'(m_cnt), 32'd1);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule